// File: doc/BRIEF.md
# Two-Slot ATM Cell Write Buffer with Trailer CRC

This block sits between a processor register port and a cell queue. Software builds a 53-byte ATM cell by writing fourteen 32-bit words into a cell slot. Writing the last word index completes the slot and hands it to the output stream. There are two slots, so software can fill one while the other waits for the downstream side to take it. Once both slots hold finished cells, the write port stalls. A stalled write is held and completes as soon as the older cell has left.

Word 0 of each slot carries a control byte and the ICI. Word 1 carries the four header bytes. Words 2 to 13 carry the 48 payload bytes. The control byte picks what happens to the payload tail as the cell streams out: nothing, a CRC-32 that runs across a multi-cell AAL5 frame and is appended to the final cell, or a one-cell OAM CRC-10. Slots keep their contents between uses, so the middle cells of a frame only need their payload rewritten.

Top module: `cellWriteBuf`

## Requirements
- R1: After reset, notFull and wrReady are 1 and outValid is 0.
- R2: A write to word index 13 completes the slot being filled. When no cell was queued, outValid is 1 in the cycle after that write is accepted. Word 0 bits 31:24 hold the control byte.
- R3: While one cell waits, a second cell can be written into the other slot. notFull drops to 0 only when both slots hold completed cells.
- R4: While both slots are full, wrReady is 0 and a write is held. The write is accepted in the cycle after the older cell's word 13 is taken, and it then lands in the freed slot.
- R5: Each cell leaves as 14 words, index 0 first. outLast is 1 on word 13 only. Cells leave in the order their slots were completed.
- R6: While outValid is 1 and outReady is 0, outValid stays 1 and outData does not change.
- R7: A word that is not rewritten keeps the value last written to that slot, and that value is sent again with the slot's next cell.
- R8: Control bits 1:0 = 00 send the payload unchanged and leave the CRC accumulator untouched.
- R9: Control bits 1:0 = 01 run the CRC-32 over payload words 2 to 13, MSB first, with polynomial 0x04C11DB7. Control bit 2 = 1 loads all ones into the accumulator before the first payload word.
- R10: Control bits 1:0 = 10 run the CRC-32 (bit 2 seeds as in R9) over words 2 to 12. Word 13 is replaced by the complement of the accumulator.
- R11: Control bits 1:0 = 11 compute a CRC-10 with polynomial 0x633, seeded with zero. It runs over words 2 to 13, with the low 10 bits of word 13 taken as zero, and the result replaces those 10 bits. This uses the shared accumulator, so the CRC-10 cell corrupts any frame CRC in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Register write request |
| wrIdx | input | 4 | Word index 0..13 inside the cell |
| wrData | input | 32 | Word to write |
| wrReady | output | 1 | Write accepted this cycle when high |
| notFull | output | 1 | A slot is free for writing |
| outValid | output | 1 | Cell word available |
| outReady | input | 1 | Downstream takes the word |
| outData | output | 32 | Cell word, trailer applied |
| outLast | output | 1 | Marks word 13 of a cell |

## Verification
Status changes one cycle after the edge that causes it. When the queue was empty, outValid rises one cycle after the word 13 write. notFull and wrReady fall one cycle after the second completion. A held write is taken on the first edge after the draining word 13 handshake. Each cell word, including its trailer, is read combinationally in the cycle in which it is presented. The bench drives every input at the falling edge and samples every output at the falling edge, half a cycle after the registers settle. It waits on outValid and wrReady rather than counting a fixed number of cycles. The expected words and CRCs come from a bench-side model of each slot's contents and of the running accumulator.

// File: rtl/cellBufPkg.sv
package cellBufPkg;
  localparam int WORD_W     = 32;
  localparam int CELL_WORDS = 14;
  localparam int SLOT_CNT   = 2;
  localparam int IDX_W      = $clog2(CELL_WORDS);
  localparam int SLOT_W     = $clog2(SLOT_CNT);
  localparam int PAY_FIRST  = 2;
  localparam int CRC10_W    = 10;

  typedef enum logic [1:0] {
    TR_NONE  = 2'b00,
    TR_RUN32 = 2'b01,
    TR_APP32 = 2'b10,
    TR_CRC10 = 2'b11
  } trailerE;

  // Strobes from control to datapath
  typedef struct packed {
    logic              wrEn;
    logic [SLOT_W-1:0] wrSlot;
    logic [IDX_W-1:0]  wrIdx;
    logic              rdFire;
    logic [SLOT_W-1:0] rdSlot;
    logic [IDX_W-1:0]  rdIdx;
  } strobeT;

  function automatic logic [31:0] crc32Step(input logic [31:0] acc,
                                            input logic [31:0] data,
                                            input logic [31:0] poly);
    logic [31:0] c;
    logic fb;
    c = acc;
    for (int i = 31; i >= 0; i--) begin
      fb = c[31] ^ data[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

  function automatic logic [CRC10_W-1:0] crc10Step(input logic [CRC10_W-1:0] acc,
                                                   input logic [31:0] data,
                                                   input logic [CRC10_W-1:0] poly);
    logic [CRC10_W-1:0] c;
    logic fb;
    c = acc;
    for (int i = 31; i >= 0; i--) begin
      fb = c[CRC10_W-1] ^ data[i];
      c  = {c[CRC10_W-2:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction
endpackage

// File: rtl/cellBufCtrl.sv
module cellBufCtrl
  import cellBufPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             outReady,
  output logic             wrReady,
  output logic             notFull,
  output logic             outValid,
  output logic             outLast,
  output strobeT           stb
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_WORDS - 1);

  logic [SLOT_CNT-1:0] slotFull, slotFullNext;
  logic [SLOT_W-1:0]   wrPtr, rdPtr;
  logic [IDX_W-1:0]    rdIdx;
  logic                wrTake, commit, rdFire, drop, idxOk;

  assign idxOk    = (wrIdx <= LAST_IDX);
  assign wrReady  = ~slotFull[wrPtr];
  assign notFull  = ~slotFull[wrPtr];
  assign wrTake   = wrValid & wrReady;
  assign commit   = wrTake & (wrIdx == LAST_IDX);
  assign outValid = slotFull[rdPtr];
  assign outLast  = outValid & (rdIdx == LAST_IDX);
  assign rdFire   = outValid & outReady;
  assign drop     = rdFire & (rdIdx == LAST_IDX);

  always_comb begin
    slotFullNext = slotFull;
    if (commit) slotFullNext[wrPtr] = 1'b1;
    if (drop)   slotFullNext[rdPtr] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotFull <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
      rdIdx    <= '0;
    end else begin
      slotFull <= slotFullNext;
      if (commit) wrPtr <= wrPtr + 1'b1;
      if (drop) begin
        rdPtr <= rdPtr + 1'b1;
        rdIdx <= '0;
      end else if (rdFire) begin
        rdIdx <= rdIdx + 1'b1;
      end
    end
  end

  always_comb begin
    stb.wrEn   = wrTake & idxOk;
    stb.wrSlot = wrPtr;
    stb.wrIdx  = wrIdx;
    stb.rdFire = rdFire;
    stb.rdSlot = rdPtr;
    stb.rdIdx  = rdIdx;
  end
endmodule

// File: rtl/cellBufData.sv
module cellBufData
  import cellBufPkg::*;
#(
  parameter logic [31:0]        CRC32_POLY = 32'h04C1_1DB7,
  parameter logic [CRC10_W-1:0] CRC10_POLY = 10'h233
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] outData
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_WORDS - 1);
  localparam logic [IDX_W-1:0] FIRST_PAY = IDX_W'(PAY_FIRST);

  logic [WORD_W-1:0] rdWordS [SLOT_CNT];
  logic [7:0]        ctrlS   [SLOT_CNT];

  for (genvar g = 0; g < SLOT_CNT; g++) begin : gSlot
    logic [WORD_W-1:0] mem [CELL_WORDS];
    always_ff @(posedge clk) begin
      if (stb.wrEn && stb.wrSlot == SLOT_W'(g)) mem[stb.wrIdx] <= wrData;
    end
    assign rdWordS[g] = mem[stb.rdIdx];
    assign ctrlS[g]   = mem[0][31:24];
  end

  logic [WORD_W-1:0]  rdWord, crcIn10, acc, seed, accNext;
  logic [7:0]         ctrlByte;
  trailerE            mode;
  logic               seedInit, isPay, isLast, isFirstPay;
  logic [31:0]        c32Next;
  logic [CRC10_W-1:0] c10Next;

  assign rdWord     = rdWordS[stb.rdSlot];
  assign ctrlByte   = ctrlS[stb.rdSlot];
  assign mode       = trailerE'(ctrlByte[1:0]);
  assign seedInit   = ctrlByte[2];
  assign isLast     = (stb.rdIdx == LAST_IDX);
  assign isFirstPay = (stb.rdIdx == FIRST_PAY);
  assign isPay      = (stb.rdIdx >= FIRST_PAY);

  always_comb begin
    seed = acc;
    if (isFirstPay) begin
      if (mode == TR_CRC10) seed = '0;
      else if (seedInit)    seed = '1;
    end
  end

  assign crcIn10 = isLast ? {rdWord[WORD_W-1:CRC10_W], {CRC10_W{1'b0}}} : rdWord;
  assign c32Next = crc32Step(seed, rdWord, CRC32_POLY);
  assign c10Next = crc10Step(seed[CRC10_W-1:0], crcIn10, CRC10_POLY);

  always_comb begin
    accNext = acc;
    if (stb.rdFire && isPay) begin
      unique case (mode)
        TR_RUN32: accNext = c32Next;
        TR_APP32: if (!isLast) accNext = c32Next;
        TR_CRC10: accNext = {{(WORD_W-CRC10_W){1'b0}}, c10Next};
        default:  accNext = acc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) acc <= '1;
    else       acc <= accNext;
  end

  always_comb begin
    outData = rdWord;
    if (isLast) begin
      if (mode == TR_APP32)      outData = ~acc;
      else if (mode == TR_CRC10) outData = {rdWord[WORD_W-1:CRC10_W], c10Next};
    end
  end
endmodule

// File: rtl/cellWriteBuf.sv
module cellWriteBuf
  import cellBufPkg::*;
#(
  parameter logic [31:0]        CRC32_POLY = 32'h04C1_1DB7,
  parameter logic [CRC10_W-1:0] CRC10_POLY = 10'h233
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [WORD_W-1:0] wrData,
  output logic              wrReady,
  output logic              notFull,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outData,
  output logic              outLast
);
  strobeT stb;

  cellBufCtrl uCtrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrIdx(wrIdx),
    .outReady(outReady), .wrReady(wrReady), .notFull(notFull),
    .outValid(outValid), .outLast(outLast), .stb(stb)
  );

  cellBufData #(.CRC32_POLY(CRC32_POLY), .CRC10_POLY(CRC10_POLY)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .outData(outData)
  );
endmodule

// File: rtl/cellBufChk.sv
module cellBufChk
  import cellBufPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic [IDX_W-1:0]  wrIdx,
  input logic              wrReady,
  input logic              notFull,
  input logic              outValid,
  input logic              outReady,
  input logic [WORD_W-1:0] outData,
  input logic              outLast
);
  logic [IDX_W-1:0] beatCnt;
  always_ff @(posedge clk) begin
    if (!rstN) beatCnt <= '0;
    else if (outValid && outReady)
      beatCnt <= (beatCnt == IDX_W'(CELL_WORDS - 1)) ? '0 : beatCnt + 1'b1;
  end

  // R1
  empty_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> notFull);
  // R2
  commit_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady && wrIdx == IDX_W'(CELL_WORDS - 1)) |=> outValid);
  // R4
  full_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !notFull |-> !wrReady);
  // R5
  last_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outLast == (beatCnt == IDX_W'(CELL_WORDS - 1))));
  // R6
  hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));
endmodule

bind cellWriteBuf cellBufChk uChk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrIdx(wrIdx), .wrReady(wrReady),
  .notFull(notFull), .outValid(outValid), .outReady(outReady),
  .outData(outData), .outLast(outLast)
);

// File: tb/sim_cellWriteBuf.sv
`timescale 1ns/1ps
module sim_cellWriteBuf;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0;
  logic [3:0] wrIdx = '0;
  logic [31:0] wrData = '0;
  logic wrReady, notFull, outValid, outLast;
  logic outReady = 1'b0;
  logic [31:0] outData;

  always #2.5 clk = ~clk;

  cellWriteBuf u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrIdx(wrIdx), .wrData(wrData),
    .wrReady(wrReady), .notFull(notFull), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outLast(outLast)
  );

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] bSlot [2][14];
  logic [31:0] expW [14];
  logic [31:0] gotW [14];
  logic        gotL [14];
  logic [31:0] bCrc = 32'hFFFF_FFFF;
  int          bPar = 0;

  // {header-write kind (0 none,1 word0,2 words0+1), control byte, seed}
  localparam bit [17:0] VEC [8] = '{
    {2'd2, 8'h00, 8'h11},   // R8 plain cell
    {2'd2, 8'h03, 8'h22},   // R11 OAM cell
    {2'd2, 8'h05, 8'h33},   // R9 frame start, init
    {2'd2, 8'h01, 8'h44},   // R9 second cell
    {2'd1, 8'h01, 8'h55},   // R9 clears init in slot
    {2'd0, 8'h00, 8'h66},   // R7 middle cell, header kept
    {2'd1, 8'h02, 8'h77},   // R10 append
    {2'd2, 8'h06, 8'h88}    // R10 single-cell frame
  };

  function automatic logic [31:0] crc32Bytes(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r = c;
    for (int b = 3; b >= 0; b--) begin
      logic [7:0] by = w[b*8 +: 8];
      for (int i = 7; i >= 0; i--)
        r = (r[31] ^ by[i]) ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
    end
    return r;
  endfunction

  function automatic logic [9:0] crc10Bytes(input logic [9:0] c, input logic [31:0] w);
    logic [10:0] r = {1'b0, c};
    for (int b = 3; b >= 0; b--) begin
      logic [7:0] by = w[b*8 +: 8];
      for (int i = 7; i >= 0; i--) begin
        r = {r[9:0], 1'b0} ^ {10'b0, 1'b0};
        if (r[10] ^ by[i]) r = r ^ 11'h633;
        r[10] = 1'b0;
      end
    end
    return r[9:0];
  endfunction

  function automatic logic [31:0] payWord(input logic [7:0] s, input int k);
    return {s, 8'(k), s ^ 8'hA5, 8'(k * 7)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    bit acc;
    @(negedge clk);
    wrValid = 1'b1; wrIdx = idx; wrData = d;
    forever begin
      acc = wrReady;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic readCell();
    @(negedge clk);
    outReady = 1'b1;
    for (int k = 0; k < 14; k++) begin
      while (!outValid) @(negedge clk);
      gotW[k] = outData;
      gotL[k] = outLast;
      @(posedge clk);
      @(negedge clk);
    end
    outReady = 1'b0;
  endtask

  task automatic modelCell(input int s);
    logic [7:0] ctl = bSlot[s][0][31:24];
    logic [9:0] c10;
    for (int k = 0; k < 14; k++) expW[k] = bSlot[s][k];
    case (ctl[1:0])
      2'b01: begin
        if (ctl[2]) bCrc = '1;
        for (int k = 2; k < 14; k++) bCrc = crc32Bytes(bCrc, bSlot[s][k]);
      end
      2'b10: begin
        if (ctl[2]) bCrc = '1;
        for (int k = 2; k < 13; k++) bCrc = crc32Bytes(bCrc, bSlot[s][k]);
        expW[13] = ~bCrc;
      end
      2'b11: begin
        c10 = '0;
        for (int k = 2; k < 13; k++) c10 = crc10Bytes(c10, bSlot[s][k]);
        c10 = crc10Bytes(c10, {bSlot[s][13][31:10], 10'b0});
        expW[13] = {bSlot[s][13][31:10], c10};
        bCrc = {22'b0, c10};
      end
      default: ;
    endcase
  endtask

  task automatic cmpCell(input string req);
    int bad = -1;
    for (int k = 13; k >= 0; k--)
      if (gotW[k] !== expW[k] || gotL[k] !== (k == 13)) bad = k;
    if (bad < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, gotW[bad], expW[bad]);
  endtask

  task automatic writeCell(input logic [1:0] hdr, input logic [7:0] ctl, input logic [7:0] s);
    if (hdr >= 2'd1) begin
      bSlot[bPar][0] = {ctl, 8'h00, s, s};
      wr(4'd0, bSlot[bPar][0]);
    end
    if (hdr == 2'd2) begin
      bSlot[bPar][1] = {s, ~s, s ^ 8'h5A, 8'h21};
      wr(4'd1, bSlot[bPar][1]);
    end
    for (int k = 2; k < 14; k++) begin
      bSlot[bPar][k] = payWord(s, k);
      wr(4'(k), bSlot[bPar][k]);
    end
    bPar ^= 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    string req;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(notFull && wrReady && !outValid, "R1", {notFull, wrReady, outValid}, 3'b110);

    for (int v = 0; v < 8; v++) begin
      int s;
      s = bPar;
      writeCell(VEC[v][17:16], VEC[v][15:8], VEC[v][7:0]);
      // R2 commit visible the cycle after word 13
      check(outValid, "R2", outValid, 1);
      readCell();
      modelCell(s);
      case (bSlot[s][0][25:24])
        2'b00: req = (VEC[v][17:16] == 2'd0) ? "R7" : "R8";
        2'b01: req = "R9";
        2'b10: req = "R10";
        default: req = "R11";
      endcase
      cmpCell(req);  // R5 word order and last flag also checked here
    end

    // R3 fill both slots without draining
    writeCell(2'd2, 8'h00, 8'h99);
    writeCell(2'd2, 8'h00, 8'hAA);
    check(!notFull && !wrReady, "R3", {notFull, wrReady}, 2'b00);
    // R5 oldest cell first
    check(outValid && outData == bSlot[0][0], "R5", outData, bSlot[0][0]);
    // R6 backpressure
    held = outData;
    repeat (4) @(negedge clk);
    check(outValid && outData == held, "R6", outData, held);

    // R4 held write
    wrValid = 1'b1; wrIdx = 4'd5; wrData = 32'hC0FF_EE55;
    repeat (3) @(negedge clk);
    check(!wrReady, "R4", wrReady, 0);
    readCell();
    modelCell(0);
    cmpCell("R5");
    check(wrReady, "R4", wrReady, 1);
    @(posedge clk);
    @(negedge clk);
    wrValid = 1'b0;
    bSlot[0][5] = 32'hC0FF_EE55;
    readCell();
    modelCell(1);
    cmpCell("R5");
    // R7 and R4: commit slot A again with only word 13 rewritten
    wr(4'd13, bSlot[0][13]);
    readCell();
    modelCell(0);
    cmpCell("R7");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule